// File: doc/BRIEF.md
# Boot Block Flash Bus Controller

This block sits on the host side of a word-wide flash device and turns the active-low chip-select, read-strobe and write-strobe pins into reads and commands. A write is taken when the write strobe rises while the chip is selected. Single-byte command codes move the read path between array, identifier and status views. A two-write sequence programs one word or one byte, and another two-write sequence erases one block. A small register file stands in for the cell array. A down-counter stands in for the time a program or an erase takes.

The 16-bit data bus can switch to a byte-wide mode. In that mode only the low eight lanes drive, and the top data pin becomes the lowest address bit, which picks the half of the word to read or to program. Two flags stand in for high-voltage pin levels. One forces the identifier view. The other unlocks the top (boot) block even when the protect input is set. A low level on the power-down input resets the control state and floats the bus. A separate power-on reset fills the stand-in array with the erased pattern.

Top module: `bbf_ctrl`

## Requirements
- R1: A command or data word is accepted only in a clock cycle where `we_n` is high, `we_n` was low in the previous cycle, and `ce_n` is low. A `we_n` pulse made while `ce_n` is high has no effect.
- R2: The command code is taken from `dq_in[7:0]` in both bus modes. 0xFF selects the array view, 0x90 selects the identifier view and 0x70 selects the status view. Any other code outside a sequence is ignored.
- R3: A 0x40 write followed by a second write programs the word at the second write's address. The stored word becomes its old value AND the written data, so program only clears bits.
- R4: When the second program write is made in byte mode, `dq_in[15]` picks the byte: 1 means the upper byte and 0 the lower one. The byte is taken from `dq_in[7:0]`, and the other byte of the word is left unchanged.
- R5: A 0x20 write followed by a 0xD0 write sets every word of the addressed block of 2^BLK_W words to 0xFFFF. Any other second code erases nothing and sets both status error bits.
- R6: The status byte is read on `dq_out[7:0]`, with `dq_out[15:8]` at zero. Bit 7 is ready, bit 5 is erase error and bit 4 is program error. After a program or erase setup write, reads show the status until another read command is given.
- R7: An accepted program or erase holds the ready bit low for BUSY_CYC cycles. Every write accepted by R1 during that window is ignored, including one on the last busy cycle.
- R8: When `boot_prot` is 1 and `unlock_hv` is 0, a program or erase aimed at the highest block is not performed. It sets the program or erase error bit, and the ready bit stays 1. With `unlock_hv` at 1 the operation is performed whatever `boot_prot` is.
- R9: While `id_hv` is 1, or in the identifier view, a read returns MFR_ID when `addr[0]` is 0 and DEV_ID when it is 1.
- R10: With `byte_n` low, `dq_out[15:8]` is zero. An array read shows the upper byte on `dq_out[7:0]` when `dq_in[15]` is 1 and the lower byte when it is 0. An identifier read shows the low identifier byte whatever `dq_in[15]` is.
- R11: `dq_oe` is 2'b00 unless `ce_n` and `oe_n` are low and `pd_n` is high. In that case it is 2'b11 in word mode and 2'b01 in byte mode.
- R12: While `pd_n` is low, the view, the pending sequence, the busy count and the error bits are cleared. On release the controller is in the array view. `por_n` low loads 0xFFFF into every array word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| por_n | input | 1 | Power-on reset for the stand-in array, active low |
| pd_n | input | 1 | Reset / deep power-down, active low |
| unlock_hv | input | 1 | High-voltage flag on the reset pin: unlocks the boot block |
| boot_prot | input | 1 | Boot block write protect, active high |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low; a write is taken on its rising edge |
| byte_n | input | 1 | Low selects the byte-wide bus mode |
| id_hv | input | 1 | High-voltage flag on address bit 9: forces the identifier view |
| addr | input | ADDR_W | Word address |
| dq_in | input | 16 | Data bus input; bit 15 is the byte select in byte mode |
| dq_out | output | 16 | Data bus output value |
| dq_oe | output | 2 | Lane drive enables: bit 0 low byte, bit 1 high byte |

## Verification
The busy counter running out and a new write strobe edge can fall in the same clock. The design must still treat the write as made while busy. The bench provokes this by counting the idle cycles after a program. It places the next 0xFF write's rising strobe first on the last busy cycle, and then on the cycle after it. It judges the two cases at the data pins: the first read must still return the status byte, and the second must return the programmed word.

// File: rtl/bbf_pkg.sv
package bbf_pkg;

   localparam int DQ_W   = 16;
   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {
      RD_ARRAY  = 2'd0,
      RD_IDENT  = 2'd1,
      RD_STATUS = 2'd2
   } rd_mode_e;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_PROG  = 2'd1,
      PH_ERASE = 2'd2
   } cmd_phase_e;

   localparam logic [7:0] CMD_RD_ARRAY  = 8'hFF;
   localparam logic [7:0] CMD_RD_IDENT  = 8'h90;
   localparam logic [7:0] CMD_RD_STATUS = 8'h70;
   localparam logic [7:0] CMD_PROG      = 8'h40;
   localparam logic [7:0] CMD_ERASE     = 8'h20;
   localparam logic [7:0] CMD_CONFIRM   = 8'hD0;

   localparam int ST_READY     = 7;
   localparam int ST_ERASE_ERR = 5;
   localparam int ST_PROG_ERR  = 4;

endpackage

// File: rtl/bbf_strobe.sv
module bbf_strobe import bbf_pkg::*; #(
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              pd_n,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic              byte_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DQ_W-1:0]   dq_in,
   output logic              wr_evt,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DQ_W-1:0]   wr_data,
   output logic              wr_byte,
   output logic              wr_bsel
);

   logic we_q;

   always_ff @(posedge clk or negedge pd_n) begin
      if (!pd_n) we_q <= 1'b1;
      else       we_q <= we_n;
   end

   // rising strobe seen with the chip selected
   assign wr_evt  = !ce_n && !we_q && we_n;
   assign wr_addr = addr;
   assign wr_data = dq_in;
   assign wr_byte = !byte_n;
   assign wr_bsel = !byte_n && dq_in[DQ_W-1];

   // R1
   wr_spacing_chk: assert property (@(posedge clk) disable iff (!pd_n)
      wr_evt |=> !wr_evt);

endmodule

// File: rtl/bbf_cui.sv
module bbf_cui import bbf_pkg::*; #(
   parameter int ADDR_W   = 4,
   parameter int BLK_W    = 2,
   parameter int BUSY_CYC = 8
) (
   input  logic              clk,
   input  logic              pd_n,
   input  logic              wr_evt,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DQ_W-1:0]   wr_data,
   input  logic              wr_byte,
   input  logic              wr_bsel,
   input  logic              boot_lock,
   output rd_mode_e          mode,
   output logic [7:0]        status,
   output logic              prog_go,
   output logic              erase_go,
   output logic [ADDR_W-1:0] op_addr,
   output logic [DQ_W-1:0]   prog_mask
);

   localparam int CNT_W = $clog2(BUSY_CYC + 1);
   localparam logic [CNT_W-1:0] BUSY_LOAD = CNT_W'(BUSY_CYC);

   generate
      if (BLK_W < 1 || BLK_W >= ADDR_W) begin : g_bad_blk
         $error("bbf_cui: BLK_W must lie in 1..ADDR_W-1");
      end
      if (BUSY_CYC < 1) begin : g_bad_busy
         $error("bbf_cui: BUSY_CYC must be at least 1");
      end
   endgenerate

   rd_mode_e         mode_q;
   cmd_phase_e       phase_q;
   logic [CNT_W-1:0] busy_cnt;
   logic             err_prog_q;
   logic             err_erase_q;

   logic       idle_ok;
   logic       acc;
   logic [7:0] cmd;
   logic       tgt_boot;
   logic       blocked;

   assign idle_ok  = (busy_cnt == '0);
   assign acc      = wr_evt && idle_ok;
   assign cmd      = wr_data[BYTE_W-1:0];
   assign tgt_boot = &wr_addr[ADDR_W-1:BLK_W];
   assign blocked  = tgt_boot && boot_lock;

   assign prog_go  = acc && (phase_q == PH_PROG) && !blocked;
   assign erase_go = acc && (phase_q == PH_ERASE) && (cmd == CMD_CONFIRM) && !blocked;
   assign op_addr  = wr_addr;

   always_comb begin
      if (!wr_byte)     prog_mask = wr_data;
      else if (wr_bsel) prog_mask = {wr_data[BYTE_W-1:0], {BYTE_W{1'b1}}};
      else              prog_mask = {{BYTE_W{1'b1}}, wr_data[BYTE_W-1:0]};
   end

   always_ff @(posedge clk or negedge pd_n) begin
      if (!pd_n) begin
         mode_q      <= RD_ARRAY;
         phase_q     <= PH_IDLE;
         busy_cnt    <= '0;
         err_prog_q  <= 1'b0;
         err_erase_q <= 1'b0;
      end else begin
         if (!idle_ok) busy_cnt <= busy_cnt - 1'b1;
         if (acc) begin
            unique case (phase_q)
               PH_PROG: begin
                  phase_q <= PH_IDLE;
                  mode_q  <= RD_STATUS;
                  if (blocked) err_prog_q <= 1'b1;
                  else         busy_cnt   <= BUSY_LOAD;
               end
               PH_ERASE: begin
                  phase_q <= PH_IDLE;
                  mode_q  <= RD_STATUS;
                  if (cmd != CMD_CONFIRM) begin
                     err_prog_q  <= 1'b1;
                     err_erase_q <= 1'b1;
                  end else if (blocked) begin
                     err_erase_q <= 1'b1;
                  end else begin
                     busy_cnt <= BUSY_LOAD;
                  end
               end
               default: begin
                  case (cmd)
                     CMD_RD_ARRAY:  mode_q <= RD_ARRAY;
                     CMD_RD_IDENT:  mode_q <= RD_IDENT;
                     CMD_RD_STATUS: mode_q <= RD_STATUS;
                     CMD_PROG: begin
                        phase_q <= PH_PROG;
                        mode_q  <= RD_STATUS;
                     end
                     CMD_ERASE: begin
                        phase_q <= PH_ERASE;
                        mode_q  <= RD_STATUS;
                     end
                     default: ;
                  endcase
               end
            endcase
         end
      end
   end

   always_comb begin
      status               = '0;
      status[ST_READY]     = idle_ok;
      status[ST_ERASE_ERR] = err_erase_q;
      status[ST_PROG_ERR]  = err_prog_q;
   end

   assign mode = mode_q;

   // R7
   busy_after_prog_chk: assert property (@(posedge clk) disable iff (!pd_n)
      prog_go |=> !status[ST_READY]);

   // R7
   busy_ignores_wr_chk: assert property (@(posedge clk) disable iff (!pd_n)
      (wr_evt && busy_cnt != '0) |=> ($stable(mode_q) && $stable(phase_q)));

   // R8
   locked_prog_chk: assert property (@(posedge clk) disable iff (!pd_n)
      (wr_evt && idle_ok && phase_q == PH_PROG && blocked)
         |=> (status[ST_PROG_ERR] && status[ST_READY]));

   // R5
   one_op_chk: assert property (@(posedge clk) disable iff (!pd_n)
      $onehot0({prog_go, erase_go}));

endmodule

// File: rtl/bbf_array.sv
module bbf_array import bbf_pkg::*; #(
   parameter int ADDR_W = 4,
   parameter int BLK_W  = 2
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              prog_go,
   input  logic              erase_go,
   input  logic [ADDR_W-1:0] op_addr,
   input  logic [DQ_W-1:0]   prog_mask,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DQ_W-1:0]   rd_word
);

   localparam int DEPTH     = 1 << ADDR_W;
   localparam int BLK_IDX_W = ADDR_W - BLK_W;

   logic [DEPTH*DQ_W-1:0] flat;

   generate
      for (genvar w = 0; w < DEPTH; w++) begin : g_word
         logic [DQ_W-1:0] cell_q;
         logic            hit_blk;
         logic            hit_word;

         assign hit_blk  = (op_addr[ADDR_W-1:BLK_W] == BLK_IDX_W'(w >> BLK_W));
         assign hit_word = (op_addr == ADDR_W'(w));

         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n)                    cell_q <= '1;
            else if (erase_go && hit_blk)  cell_q <= '1;
            else if (prog_go && hit_word)  cell_q <= cell_q & prog_mask;
         end

         assign flat[w*DQ_W +: DQ_W] = cell_q;
      end
   endgenerate

   assign rd_word = flat[rd_addr*DQ_W +: DQ_W];

endmodule

// File: rtl/bbf_dqmux.sv
module bbf_dqmux import bbf_pkg::*; #(
   parameter logic [DQ_W-1:0] MFR_ID = 16'h00C3,
   parameter logic [DQ_W-1:0] DEV_ID = 16'h5A27
) (
   input  rd_mode_e        mode,
   input  logic            id_hv,
   input  logic            id_sel,
   input  logic            byte_n,
   input  logic            hi_sel,
   input  logic            ce_n,
   input  logic            oe_n,
   input  logic            pd_n,
   input  logic [DQ_W-1:0] arr_word,
   input  logic [7:0]      status,
   output logic [DQ_W-1:0] dq_out,
   output logic [1:0]      dq_oe
);

   logic [DQ_W-1:0] id_word;
   logic            drive;

   assign id_word = id_sel ? DEV_ID : MFR_ID;
   assign drive   = !ce_n && !oe_n && pd_n;
   assign dq_oe   = {drive && byte_n, drive};

   always_comb begin
      if (id_hv || mode == RD_IDENT) begin
         if (byte_n) dq_out = id_word;
         else        dq_out = {{BYTE_W{1'b0}}, id_word[BYTE_W-1:0]};
      end else if (mode == RD_STATUS) begin
         dq_out = {{BYTE_W{1'b0}}, status};
      end else if (byte_n) begin
         dq_out = arr_word;
      end else if (hi_sel) begin
         dq_out = {{BYTE_W{1'b0}}, arr_word[DQ_W-1:BYTE_W]};
      end else begin
         dq_out = {{BYTE_W{1'b0}}, arr_word[BYTE_W-1:0]};
      end
   end

endmodule

// File: rtl/bbf_ctrl.sv
module bbf_ctrl import bbf_pkg::*; #(
   parameter int              ADDR_W   = 4,
   parameter int              BLK_W    = 2,
   parameter int              BUSY_CYC = 8,
   parameter logic [DQ_W-1:0] MFR_ID   = 16'h00C3,
   parameter logic [DQ_W-1:0] DEV_ID   = 16'h5A27
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              pd_n,
   input  logic              unlock_hv,
   input  logic              boot_prot,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic              byte_n,
   input  logic              id_hv,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DQ_W-1:0]   dq_in,
   output logic [DQ_W-1:0]   dq_out,
   output logic [1:0]        dq_oe
);

   logic              wr_evt;
   logic [ADDR_W-1:0] wr_addr;
   logic [DQ_W-1:0]   wr_data;
   logic              wr_byte;
   logic              wr_bsel;
   rd_mode_e          mode;
   logic [7:0]        status;
   logic              prog_go;
   logic              erase_go;
   logic [ADDR_W-1:0] op_addr;
   logic [DQ_W-1:0]   prog_mask;
   logic [DQ_W-1:0]   arr_word;
   logic              boot_lock;

   // high-voltage unlock overrides the protect input
   assign boot_lock = boot_prot && !unlock_hv;

   bbf_strobe #(.ADDR_W(ADDR_W)) u_strobe (
      .clk(clk), .pd_n(pd_n), .ce_n(ce_n), .we_n(we_n), .byte_n(byte_n),
      .addr(addr), .dq_in(dq_in), .wr_evt(wr_evt), .wr_addr(wr_addr),
      .wr_data(wr_data), .wr_byte(wr_byte), .wr_bsel(wr_bsel)
   );

   bbf_cui #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .BUSY_CYC(BUSY_CYC)) u_cui (
      .clk(clk), .pd_n(pd_n), .wr_evt(wr_evt), .wr_addr(wr_addr),
      .wr_data(wr_data), .wr_byte(wr_byte), .wr_bsel(wr_bsel),
      .boot_lock(boot_lock), .mode(mode), .status(status),
      .prog_go(prog_go), .erase_go(erase_go), .op_addr(op_addr),
      .prog_mask(prog_mask)
   );

   bbf_array #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_array (
      .clk(clk), .por_n(por_n), .prog_go(prog_go), .erase_go(erase_go),
      .op_addr(op_addr), .prog_mask(prog_mask), .rd_addr(addr),
      .rd_word(arr_word)
   );

   bbf_dqmux #(.MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_dqmux (
      .mode(mode), .id_hv(id_hv), .id_sel(addr[0]), .byte_n(byte_n),
      .hi_sel(dq_in[DQ_W-1]), .ce_n(ce_n), .oe_n(oe_n), .pd_n(pd_n),
      .arr_word(arr_word), .status(status), .dq_out(dq_out), .dq_oe(dq_oe)
   );

   // R11
   oe_gate_chk: assert property (@(posedge clk) disable iff (!pd_n)
      (ce_n || oe_n) |-> (dq_oe == 2'b00));

   // R10
   byte_lane_chk: assert property (@(posedge clk) disable iff (!pd_n)
      !byte_n |-> (!dq_oe[1] && dq_out[DQ_W-1:BYTE_W] == '0));

endmodule

// File: tb/bbf_ctrl_tb.sv
`timescale 1ns/1ps
module bbf_ctrl_tb;

   localparam int BUSY = 8;
   localparam int NV   = 31;

   // [43:40] req, [39:38] kind (0 write, 1 read), [37] byte_n, [36] byte select,
   // [35:32] addr, [31:16] write data, [15:0] expected read
   localparam logic [43:0] VEC [NV] = '{
      {4'd12, 2'd1, 1'b1, 1'b0, 4'd3, 16'h0000, 16'hFFFF}, // R12 erased at power-on
      {4'd3,  2'd0, 1'b1, 1'b0, 4'd0, 16'h0040, 16'h0000}, // R3 setup
      {4'd3,  2'd0, 1'b1, 1'b0, 4'd3, 16'h1234, 16'h0000},
      {4'd6,  2'd1, 1'b1, 1'b0, 4'd0, 16'h0000, 16'h0080}, // R6 status view after program
      {4'd2,  2'd0, 1'b1, 1'b0, 4'd0, 16'h00FF, 16'h0000}, // R2
      {4'd3,  2'd1, 1'b1, 1'b0, 4'd3, 16'h0000, 16'h1234},
      {4'd3,  2'd0, 1'b1, 1'b0, 4'd0, 16'h0040, 16'h0000}, // R3 AND program
      {4'd3,  2'd0, 1'b1, 1'b0, 4'd3, 16'h00F0, 16'h0000},
      {4'd2,  2'd0, 1'b1, 1'b0, 4'd0, 16'h00FF, 16'h0000},
      {4'd3,  2'd1, 1'b1, 1'b0, 4'd3, 16'h0000, 16'h0030},
      {4'd4,  2'd0, 1'b1, 1'b0, 4'd0, 16'h0040, 16'h0000}, // R4 upper byte
      {4'd4,  2'd0, 1'b0, 1'b1, 4'd8, 16'h00A5, 16'h0000},
      {4'd4,  2'd0, 1'b1, 1'b0, 4'd0, 16'h0040, 16'h0000}, // R4 lower byte
      {4'd4,  2'd0, 1'b0, 1'b0, 4'd8, 16'h005A, 16'h0000},
      {4'd2,  2'd0, 1'b1, 1'b0, 4'd0, 16'h00FF, 16'h0000},
      {4'd4,  2'd1, 1'b1, 1'b0, 4'd8, 16'h0000, 16'hA55A},
      {4'd10, 2'd1, 1'b0, 1'b1, 4'd8, 16'h0000, 16'h00A5}, // R10
      {4'd10, 2'd1, 1'b0, 1'b0, 4'd8, 16'h0000, 16'h005A},
      {4'd2,  2'd0, 1'b1, 1'b0, 4'd0, 16'h0090, 16'h0000},
      {4'd9,  2'd1, 1'b1, 1'b0, 4'd0, 16'h0000, 16'h00C3}, // R9
      {4'd9,  2'd1, 1'b1, 1'b0, 4'd1, 16'h0000, 16'h5A27},
      {4'd2,  2'd0, 1'b1, 1'b0, 4'd0, 16'h0070, 16'h0000},
      {4'd6,  2'd1, 1'b1, 1'b0, 4'd5, 16'h0000, 16'h0080},
      {4'd3,  2'd0, 1'b1, 1'b0, 4'd0, 16'h0040, 16'h0000},
      {4'd3,  2'd0, 1'b1, 1'b0, 4'd4, 16'h0F0F, 16'h0000},
      {4'd5,  2'd0, 1'b1, 1'b0, 4'd5, 16'h0020, 16'h0000}, // R5 erase block 1
      {4'd5,  2'd0, 1'b1, 1'b0, 4'd5, 16'h00D0, 16'h0000},
      {4'd2,  2'd0, 1'b1, 1'b0, 4'd0, 16'h00FF, 16'h0000},
      {4'd5,  2'd1, 1'b1, 1'b0, 4'd4, 16'h0000, 16'hFFFF},
      {4'd5,  2'd1, 1'b1, 1'b0, 4'd8, 16'h0000, 16'hA55A},
      {4'd5,  2'd1, 1'b1, 1'b0, 4'd3, 16'h0000, 16'h0030}
   };

   logic        clk = 1'b0;
   logic        por_n = 1'b0, pd_n = 1'b0, unlock_hv = 1'b0, boot_prot = 1'b0;
   logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, byte_n = 1'b1, id_hv = 1'b0;
   logic [3:0]  addr = '0;
   logic [15:0] dq_in = '0;
   logic [15:0] dq_out;
   logic [1:0]  dq_oe;

   int  n_run  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;

   always #4 clk = ~clk;

   bbf_ctrl #(.BUSY_CYC(BUSY)) u_dut (
      .clk(clk), .por_n(por_n), .pd_n(pd_n), .unlock_hv(unlock_hv),
      .boot_prot(boot_prot), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .byte_n(byte_n), .id_hv(id_hv), .addr(addr), .dq_in(dq_in),
      .dq_out(dq_out), .dq_oe(dq_oe)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   // called at a negedge; the write is taken on the second following posedge
   task automatic wr(input logic [3:0] a, input logic [15:0] d, input logic bn, input logic bs);
      byte_n = bn;
      addr   = a;
      dq_in  = bn ? d : {bs, d[14:0]};
      ce_n   = 1'b0;
      we_n   = 1'b0;
      @(negedge clk);
      we_n = 1'b1;
      @(negedge clk);
      ce_n   = 1'b1;
      byte_n = 1'b1;
   endtask

   task automatic rd(input logic [3:0] a, input logic bn, input logic bs,
                     input logic [15:0] exp, input string req);
      byte_n    = bn;
      addr      = a;
      dq_in[15] = bs;
      ce_n      = 1'b0;
      oe_n      = 1'b0;
      #2;
      check(req, dq_out, exp);
      check({req, " lane enables"}, {14'd0, dq_oe}, bn ? 16'd3 : 16'd1);
      ce_n   = 1'b1;
      oe_n   = 1'b1;
      byte_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic settle();
      repeat (BUSY + 2) @(negedge clk);
   endtask

   task automatic pd_pulse();
      pd_n = 1'b0;
      repeat (2) @(negedge clk);
      pd_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      ce_n = 1'b0; oe_n = 1'b0; #1;
      check("R11 oe low in reset", {14'd0, dq_oe}, 16'd0);
      ce_n = 1'b1; oe_n = 1'b1;
      por_n = 1'b1;
      pd_n  = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i][39:38] == 2'd0) begin
            wr(VEC[i][35:32], VEC[i][31:16], VEC[i][37], VEC[i][36]);
            settle();
         end else begin
            rd(VEC[i][35:32], VEC[i][37], VEC[i][36], VEC[i][15:0],
               $sformatf("R%0d vector %0d", VEC[i][43:40], i));
         end
      end

      // R1: strobe with chip deselected is ignored
      addr = 4'd0; dq_in = 16'h0090; we_n = 1'b0;
      @(negedge clk); we_n = 1'b1; @(negedge clk);
      rd(4'd0, 1'b1, 1'b0, 16'hFFFF, "R1 deselected write");

      // R11: either strobe high keeps the bus floating
      ce_n = 1'b0; oe_n = 1'b1; #1;
      check("R11 oe_n high", {14'd0, dq_oe}, 16'd0);
      ce_n = 1'b1; oe_n = 1'b0; #1;
      check("R11 ce_n high", {14'd0, dq_oe}, 16'd0);
      oe_n = 1'b1;
      @(negedge clk);

      // R7: ready low right after program
      wr(4'd0, 16'h0040, 1'b1, 1'b0);
      wr(4'd2, 16'h00FF, 1'b1, 1'b0);
      rd(4'd2, 1'b1, 1'b0, 16'h0000, "R7 busy status");
      settle();
      rd(4'd2, 1'b1, 1'b0, 16'h0080, "R7 ready again");

      // R7: write on the last busy cycle is ignored
      wr(4'd0, 16'h0040, 1'b1, 1'b0);
      wr(4'd6, 16'h1111, 1'b1, 1'b0);
      repeat (BUSY - 2) @(negedge clk);
      wr(4'd0, 16'h00FF, 1'b1, 1'b0);
      rd(4'd6, 1'b1, 1'b0, 16'h0080, "R7 last busy cycle write");
      // one cycle later it is taken
      wr(4'd0, 16'h0040, 1'b1, 1'b0);
      wr(4'd7, 16'h2222, 1'b1, 1'b0);
      repeat (BUSY - 1) @(negedge clk);
      wr(4'd0, 16'h00FF, 1'b1, 1'b0);
      rd(4'd7, 1'b1, 1'b0, 16'h2222, "R7 first idle cycle write");

      // R8: locked boot block
      boot_prot = 1'b1;
      wr(4'd0, 16'h0040, 1'b1, 1'b0);
      wr(4'd13, 16'h0000, 1'b1, 1'b0);
      rd(4'd0, 1'b1, 1'b0, 16'h0090, "R8 locked program status");
      wr(4'd0, 16'h00FF, 1'b1, 1'b0);
      rd(4'd13, 1'b1, 1'b0, 16'hFFFF, "R8 locked word unchanged");
      wr(4'd12, 16'h0020, 1'b1, 1'b0);
      wr(4'd12, 16'h00D0, 1'b1, 1'b0);
      rd(4'd0, 1'b1, 1'b0, 16'h00B0, "R8 locked erase status");

      // R12: power-down floats bus, clears state, returns to array view
      pd_n = 1'b0; ce_n = 1'b0; oe_n = 1'b0; #1;
      check("R12 bus floats in power-down", {14'd0, dq_oe}, 16'd0);
      ce_n = 1'b1; oe_n = 1'b1;
      @(negedge clk); @(negedge clk);
      pd_n = 1'b1;
      @(negedge clk);
      rd(4'd7, 1'b1, 1'b0, 16'h2222, "R12 array view after release");
      wr(4'd0, 16'h0070, 1'b1, 1'b0);
      rd(4'd0, 1'b1, 1'b0, 16'h0080, "R12 errors cleared");

      // R8: high-voltage unlock overrides protect
      unlock_hv = 1'b1;
      wr(4'd0, 16'h0040, 1'b1, 1'b0);
      wr(4'd13, 16'h1357, 1'b1, 1'b0);
      settle();
      wr(4'd0, 16'h00FF, 1'b1, 1'b0);
      rd(4'd13, 1'b1, 1'b0, 16'h1357, "R8 unlocked program");
      unlock_hv = 1'b0;
      boot_prot = 1'b0;

      // R5: bad confirm code
      wr(4'd0, 16'h0020, 1'b1, 1'b0);
      wr(4'd0, 16'h0055, 1'b1, 1'b0);
      rd(4'd0, 1'b1, 1'b0, 16'h00B0, "R5 bad confirm status");
      wr(4'd0, 16'h00FF, 1'b1, 1'b0);
      rd(4'd3, 1'b1, 1'b0, 16'h0030, "R5 bad confirm no erase");
      pd_pulse();

      // R9 / R10: signature flag forces identifiers
      id_hv = 1'b1;
      rd(4'd1, 1'b1, 1'b0, 16'h5A27, "R9 flag device id");
      rd(4'd1, 1'b0, 1'b1, 16'h0027, "R10 id low byte hi-sel set");
      rd(4'd0, 1'b0, 1'b0, 16'h00C3, "R10 id low byte hi-sel clear");
      id_hv = 1'b0;

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule